// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencing Controller

This block adds two unsigned W-bit operands one bit position per clock cycle. It uses a single full-adder cell and a one-bit carry register. The operands are captured into two right-shifting registers when a start pulse arrives. On each cycle the lowest bits of both operand registers and the stored carry feed the full adder. The sum bit enters the top of a result register that also shifts right, so after W cycles the whole sum sits in bit order in that register.

A small controller sequences the addition. It moves through three states: idle, run and done. A start pulse in idle loads the operands, clears the carry and begins the run. A down-counter loaded with W-1 sets the run to exactly W add/shift cycles. The controller then raises a one-cycle done indication and returns to idle. The sum and the final carry stay on the outputs until the next addition starts. A start pulse that arrives while an addition is in progress, or during the done cycle, has no effect. W is a parameter with a default of 8 and must be at least 2.

Top module: `serial_add_unit`

## Requirements
- R1: After reset, busyOut, doneOut, carryOut and every bit of sumOut are 0.
- R2: When startIn is 1 at a rising edge while the unit is idle, busyOut is 1 from that edge on.
- R3: An accepted start is followed by exactly W add/shift cycles. busyOut stays high for those W cycles, and doneOut rises at the W-th rising edge after the start edge.
- R4: While doneOut is 1, sumOut equals (A + B) mod 2^W for the operands present at the accepted start.
- R5: While doneOut is 1, carryOut equals bit W of A + B, the final carry left in the carry register.
- R6: The carry register is cleared when an addition starts, so a carry of 1 left from the previous addition does not enter the new sum.
- R7: startIn is ignored during the run and during the done cycle. It does not reload the operands, does not change the timing of doneOut, and does not start a new addition.
- R8: doneOut is high for exactly one cycle, after which busyOut and doneOut are 0 and a new start is accepted.
- R9: While idle, sumOut and carryOut keep their values from the last completed addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start request, taken only while idle |
| opA | input | W | First operand, captured at the accepted start |
| opB | input | W | Second operand, captured at the accepted start |
| sumOut | output | W | Result register contents |
| carryOut | output | 1 | Carry register contents, the final carry-out after a run |
| busyOut | output | 1 | High during the W add/shift cycles |
| doneOut | output | 1 | One-cycle completion indication |

## Verification
Some properties are checked on every cycle by assertions. These are the one-cycle width of done and the step from an accepted start into the run. They also cover the move to done when the counter reaches zero, the counter stepping on through a start pulse sent mid-run, the carry clear at load, and the result holding while no strobe is active. Other behaviour can only be shown by the bench's directed scenarios, which compare against sums the bench computes itself. These cover the arithmetic value of the sum and the final carry, the exact count of W cycles between start and done, and a stale carry failing to leak into the next sum. They also cover ignored start pulses failing to change the operands, and the values holding across idle cycles.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic loadOps;
    logic clearCarry;
    logic shiftEn;
  } ctl_strobes_t;

endpackage

// File: rtl/serial_full_adder.sv
module serial_full_adder (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  logic propBit;
  logic genBit;

  always_comb begin
    propBit = aBit ^ bBit;
    genBit  = aBit & bBit;
    sBit    = propBit ^ cIn;
    cOut    = genBit | (propBit & cIn);
  end
endmodule

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl
  import serial_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output ctl_strobes_t strobes,
  output logic         busyOut,
  output logic         doneOut
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  seq_state_t stateQ, stateD;
  logic [CW-1:0] runCount, runCountD;
  logic acceptStart;

  always_comb begin
    acceptStart = (stateQ == ST_IDLE) && startIn;
    stateD      = stateQ;
    runCountD   = runCount;
    case (stateQ)
      ST_IDLE: begin
        if (acceptStart) begin
          stateD    = ST_RUN;
          runCountD = LAST_STEP;
        end
      end
      ST_RUN: begin
        if (runCount == '0) begin
          stateD = ST_DONE;
        end else begin
          runCountD = runCount - 1'b1;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      runCount <= '0;
    end else begin
      stateQ   <= stateD;
      runCount <= runCountD;
    end
  end

  always_comb begin
    strobes.loadOps    = acceptStart;
    strobes.clearCarry = acceptStart;
    strobes.shiftEn    = (stateQ == ST_RUN);
    busyOut            = (stateQ == ST_RUN);
    doneOut            = (stateQ == ST_DONE);
  end

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R2: an idle start enters the run
  p_start_enters_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && startIn) |=> busyOut);

  // R3: the last counted step leads to done
  p_last_step_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && runCount == '0) |=> doneOut);

  // R7: a start pulse mid-run does not reload the counter
  p_run_ignores_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn && runCount != '0) |=>
      (busyOut && runCount == $past(runCount) - 1'b1));

  // R7: a start pulse in the done cycle returns to idle, not to the run
  p_done_ignores_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && startIn) |=> (!busyOut && !doneOut));
endmodule

// File: rtl/serial_add_path.sv
module serial_add_path
  import serial_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctl_strobes_t strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W-1:0] aShift;
  logic [W-1:0] bShift;
  logic [W-1:0] sumShift;
  logic         carryReg;
  logic         sumBit;
  logic         carryNext;

  serial_full_adder u_fa (
    .aBit (aShift[0]),
    .bBit (bShift[0]),
    .cIn  (carryReg),
    .sBit (sumBit),
    .cOut (carryNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aShift   <= '0;
      bShift   <= '0;
      sumShift <= '0;
    end else if (strobes.loadOps) begin
      aShift   <= opA;
      bShift   <= opB;
      sumShift <= '0;
    end else if (strobes.shiftEn) begin
      aShift   <= {1'b0, aShift[W-1:1]};
      bShift   <= {1'b0, bShift[W-1:1]};
      sumShift <= {sumBit, sumShift[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryReg <= 1'b0;
    end else if (strobes.clearCarry) begin
      carryReg <= 1'b0;
    end else if (strobes.shiftEn) begin
      carryReg <= carryNext;
    end
  end

  assign sumOut   = sumShift;
  assign carryOut = carryReg;

  // R6: a start clears the carry register
  p_carry_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCarry |=> (carryReg == 1'b0));

  // R9: with no strobe the result and carry hold
  p_result_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadOps && !strobes.shiftEn) |=> ($stable(sumShift) && $stable(carryReg)));
endmodule

// File: rtl/serial_add_unit.sv
module serial_add_unit
  import serial_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut,
  output logic         carryOut,
  output logic         busyOut,
  output logic         doneOut
);
  ctl_strobes_t strobes;

  serial_add_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobes (strobes),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  serial_add_path #(.W(W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );
endmodule

// File: tb/serial_add_unit_bench.sv
`timescale 1ns/1ps
module serial_add_unit_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] sumOut;
  logic carryOut, busyOut, doneOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_add_unit #(.W(W)) u_serial_add_unit (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opA(opA), .opB(opB),
    .sumOut(sumOut), .carryOut(carryOut), .busyOut(busyOut), .doneOut(doneOut)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One full addition with cycle-exact timing checks (R2 R3 R4 R5 R8 R9)
  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    opA = a; opB = b; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    checkVal("R2", "busy after start", 32'(busyOut), 32'd1);
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      checkVal("R3", "done early", 32'(doneOut), 32'd0);
    end
    @(negedge clk);
    checkVal("R3", "done at W", 32'(doneOut), 32'd1);
    checkVal("R4", "sum", 32'(sumOut), 32'(full[W-1:0]));
    checkVal("R5", "carry", 32'(carryOut), 32'(full[W]));
    @(negedge clk);
    checkVal("R8", "done width", 32'(doneOut), 32'd0);
    checkVal("R8", "busy after done", 32'(busyOut), 32'd0);
    @(negedge clk);
    checkVal("R9", "sum held", 32'(sumOut), 32'(full[W-1:0]));
    checkVal("R9", "carry held", 32'(carryOut), 32'(full[W]));
  endtask

  task automatic testReset();
    checkVal("R1", "busy", 32'(busyOut), 32'd0);
    checkVal("R1", "done", 32'(doneOut), 32'd0);
    checkVal("R1", "sum", 32'(sumOut), 32'd0);
    checkVal("R1", "carry", 32'(carryOut), 32'd0);
  endtask

  task automatic testCorners();
    runAdd('0, '0);
    runAdd('1, W'(1));
    runAdd('1, '1);
    runAdd({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}});
    runAdd({(W/2){2'b10}}, {(W/2){2'b01}});
  endtask

  // R6: a carry of 1 from the previous run must not leak in
  task automatic testCarryClear();
    runAdd('1, W'(1));
    checkVal("R6", "stale carry present", 32'(carryOut), 32'd1);
    runAdd('0, '0);
    checkVal("R6", "sum after stale carry", 32'(sumOut), 32'd0);
  endtask

  // R7: start pulses mid-run and in the done cycle are ignored
  task automatic testIgnoreStart();
    @(negedge clk);
    opA = W'(3); opB = W'(4); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    opA = W'(200); opB = W'(100); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int i = 4; i < W; i++) begin
      @(negedge clk);
      checkVal("R7", "done early after mid start", 32'(doneOut), 32'd0);
    end
    @(negedge clk);
    checkVal("R7", "done timing", 32'(doneOut), 32'd1);
    checkVal("R7", "sum of original operands", 32'(sumOut), 32'd7);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    checkVal("R7", "no run from done-cycle start", 32'(busyOut), 32'd0);
    @(negedge clk);
    checkVal("R7", "still idle", 32'(busyOut), 32'd0);
    checkVal("R7", "sum kept", 32'(sumOut), 32'd7);
  endtask

  task automatic testIdleHold();
    runAdd(W'(90), W'(200));
    for (int i = 0; i < 5; i++) @(negedge clk);
    opA = W'(1); opB = W'(2);
    @(negedge clk);
    checkVal("R9", "sum after idle", 32'(sumOut), 32'((90 + 200) % (1 << W)));
    checkVal("R9", "carry after idle", 32'(carryOut), 32'(((90 + 200) >> W) & 1));
  endtask

  task automatic testRandom();
    for (int n = 0; n < 24; n++) begin
      runAdd(W'($urandom), W'($urandom));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCorners();
    testCarryClear();
    testIgnoreStart();
    testIdleHold();
    testRandom();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule